// File: doc/BRIEF.md
# Backplane Bus Requester with Grant Daisy Chain

This block is the arbitration front end of one master on a shared parallel backplane. The backplane has four prioritised request levels. Each level has a request line shared by all slots and a grant line threaded through the slots as a daisy chain. When local logic wants the bus, the block raises the request line of one chosen level. It then waits for the grant of that level to arrive on its grant input. When the grant arrives, it drives bus-busy and reports ownership to the local transfer engine.

The block does not keep grants it has no use for. A grant on any other level, or on its own level while it is not requesting, goes on to the next slot, so the chain never stays open. An optional fair mode holds back a new request while another master already holds the same request line. A grant input is acted on only after it passes a synchroniser and a short stability filter. All vectors are active-high inside the block. Bit i of every request and grant vector belongs to level i.

Top module: `busReqChain`

## Requirements
- R1: While `rstN` is low, `reqOut`, `grantOut`, `busBusyOut` and `owned` are all zero.
- R2: With the block idle and `xferReq` high, `reqOut` becomes the one-hot vector with bit `levelSel` set, one clock edge later. `levelSel` is a binary level index and is taken only while idle. A change to it during a request or ownership does not move the request.
- R3: While requesting, a grant on the own level that stays high makes `busBusyOut` and `owned` rise at the fourth clock edge after it is first sampled, provided `busBusyIn` is low. While owning, the own-level bit of `grantOut` stays low.
- R4: While `busBusyIn` is high, a requesting block does not claim even with a stable own grant. It claims at the first edge after `busBusyIn` falls.
- R5: For every level other than the own level, `grantOut[i]` equals `grantIn[i]` delayed by two clock edges, whatever state the block is in.
- R6: An own-level grant that arrives while the block is not requesting appears on `grantOut` at the fourth edge. It keeps being forwarded until `grantIn` falls, and `grantOut` drops at the third edge after that. A request raised during forwarding is issued only once forwarding has ended.
- R7: With `fairMode` high, an idle block does not raise a request while `reqIn` of its level is high. It raises the request one edge after that line falls. With `fairMode` low, `reqIn` has no effect.
- R8: An own-level grant pulse one clock long is neither claimed nor forwarded.
- R9: A one-cycle `xferDone` pulse while owning clears `busBusyOut`, `owned` and `reqOut` at the same edge.
- R10: After a release, the own-level grant is not forwarded until `grantIn` of that level has first gone low.
- R11: Dropping `xferReq` before the bus is claimed clears `reqOut` at the next edge.
- R12: `reqOut` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| levelSel | input | 2 | Binary index of the request level to use |
| fairMode | input | 1 | Enables deferral behind other requesters on the same level |
| xferReq | input | 1 | Local logic wants the bus |
| xferDone | input | 1 | One-cycle pulse: the local transfer has finished |
| grantIn | input | 4 | Grant chain inputs, one per level |
| reqIn | input | 4 | Observed state of the shared request lines |
| busBusyIn | input | 1 | Bus-busy driven by some other master |
| reqOut | output | 4 | Request line drive, one-hot or zero |
| grantOut | output | 4 | Grant chain outputs to the next slot |
| busBusyOut | output | 1 | Bus-busy drive of this master |
| owned | output | 1 | This master holds the bus |

## Verification
The properties assume four things about the inputs. `xferDone` arrives only as a single-cycle pulse while the bus is owned. `busBusyIn` reflects only other masters. `reqIn` is the wired state of the lines, which includes the block's own drive. `levelSel` is meaningful only while the block is idle. The stimulus follows all four: it drives inputs on the falling clock edge, and it raises `xferDone` only after ownership has been observed. It drops grants only once the block has either claimed the bus or returned to idle.

// File: rtl/busReqPkg.sv
package busReqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_OWN,
    ST_FWD,
    ST_HOLD
  } reqState_e;

  typedef struct packed {
    logic lvlLoad;
    logic reqDrive;
    logic claim;
    logic fwdOwn;
  } ctrlStrb_t;

endpackage

// File: rtl/grantSync.sv
module grantSync #(
  parameter int NUM_LEVELS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] grantIn,
  output logic [NUM_LEVELS-1:0] gSync,
  output logic [NUM_LEVELS-1:0] gQual
);

  logic [NUM_LEVELS-1:0] gPrev;

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], grantIn[i]};
    end
    assign gSync[i] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gPrev <= '0;
    else       gPrev <= gSync;
  end

  assign gQual = gSync & gPrev;

endmodule

// File: rtl/reqDatapath.sv
module reqDatapath
  import busReqPkg::*;
#(
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrb_t             strb,
  input  logic [LVL_W-1:0]      levelSel,
  input  logic [NUM_LEVELS-1:0] gSync,
  input  logic [NUM_LEVELS-1:0] gQual,
  input  logic [NUM_LEVELS-1:0] reqIn,
  output logic [LVL_W-1:0]      lvlQ,
  output logic                  ownSync,
  output logic                  ownQual,
  output logic                  ownReqIn,
  output logic [NUM_LEVELS-1:0] reqOut,
  output logic [NUM_LEVELS-1:0] grantOut,
  output logic                  busBusyOut,
  output logic                  owned
);

  logic [LVL_W-1:0] effLvl;

  assign effLvl = strb.lvlLoad ? levelSel : lvlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlQ <= '0;
    else       lvlQ <= effLvl;
  end

  assign ownSync  = gSync[effLvl];
  assign ownQual  = gQual[effLvl];
  assign ownReqIn = reqIn[effLvl];

  assign reqOut = strb.reqDrive ? (NUM_LEVELS'(1) << lvlQ) : '0;

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_fwd
    assign grantOut[i] = (effLvl == LVL_W'(i)) ? strb.fwdOwn : gSync[i];
  end

  assign busBusyOut = strb.claim;
  assign owned      = strb.claim;

endmodule

// File: rtl/reqCtrl.sv
module reqCtrl
  import busReqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      xferReq,
  input  logic      xferDone,
  input  logic      fairMode,
  input  logic      busBusyIn,
  input  logic      ownSync,
  input  logic      ownQual,
  input  logic      ownReqIn,
  output ctrlStrb_t strb
);

  reqState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (ownQual)                              stateD = ST_FWD;
        else if (xferReq && !(fairMode && ownReqIn)) stateD = ST_REQ;
      end
      ST_REQ: begin
        if (!xferReq)                    stateD = ST_IDLE;
        else if (ownQual && !busBusyIn)  stateD = ST_OWN;
      end
      ST_OWN:  if (xferDone) stateD = ST_HOLD;
      ST_FWD:  if (!ownSync) stateD = ST_IDLE;
      ST_HOLD: if (!ownSync) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb.lvlLoad  = (stateQ == ST_IDLE);
    strb.reqDrive = (stateQ == ST_REQ) || (stateQ == ST_OWN);
    strb.claim    = (stateQ == ST_OWN);
    strb.fwdOwn   = (stateQ == ST_FWD);
  end

endmodule

// File: rtl/busReqChain.sv
module busReqChain
  import busReqPkg::*;
#(
  parameter int NUM_LEVELS  = 4,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LVL_W-1:0]      levelSel,
  input  logic                  fairMode,
  input  logic                  xferReq,
  input  logic                  xferDone,
  input  logic [NUM_LEVELS-1:0] grantIn,
  input  logic [NUM_LEVELS-1:0] reqIn,
  input  logic                  busBusyIn,
  output logic [NUM_LEVELS-1:0] reqOut,
  output logic [NUM_LEVELS-1:0] grantOut,
  output logic                  busBusyOut,
  output logic                  owned
);

  ctrlStrb_t             strb;
  logic [NUM_LEVELS-1:0] gSync, gQual;
  logic [LVL_W-1:0]      curLvl;
  logic                  ownSync, ownQual, ownReqIn;

  grantSync #(.NUM_LEVELS(NUM_LEVELS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .grantIn(grantIn), .gSync(gSync), .gQual(gQual)
  );

  reqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .xferReq(xferReq), .xferDone(xferDone),
    .fairMode(fairMode), .busBusyIn(busBusyIn), .ownSync(ownSync),
    .ownQual(ownQual), .ownReqIn(ownReqIn), .strb(strb)
  );

  reqDatapath #(.NUM_LEVELS(NUM_LEVELS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .levelSel(levelSel),
    .gSync(gSync), .gQual(gQual), .reqIn(reqIn), .lvlQ(curLvl),
    .ownSync(ownSync), .ownQual(ownQual), .ownReqIn(ownReqIn),
    .reqOut(reqOut), .grantOut(grantOut), .busBusyOut(busBusyOut),
    .owned(owned)
  );

endmodule

// File: rtl/busReqChainChk.sv
module busReqChainChk #(
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  fairMode,
  input logic                  xferDone,
  input logic                  busBusyIn,
  input logic [NUM_LEVELS-1:0] reqIn,
  input logic [NUM_LEVELS-1:0] reqOut,
  input logic [NUM_LEVELS-1:0] grantOut,
  input logic                  busBusyOut,
  input logic [LVL_W-1:0]      curLvl
);

  // R12
  single_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqOut));

  // R4
  no_steal_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busBusyOut) |-> !$past(busBusyIn));

  // R3
  claim_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busBusyOut) |-> ($past(reqOut) != '0));

  // R3
  own_grant_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    busBusyOut |-> !grantOut[curLvl]);

  // R9
  release_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busBusyOut) |-> $past(xferDone));

  // R7
  fair_defer_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((reqOut != '0) && ($past(reqOut) == '0) && $past(fairMode))
      |-> (($past(reqIn) & reqOut) == '0));

endmodule

bind busReqChain busReqChainChk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
  .clk(clk), .rstN(rstN), .fairMode(fairMode), .xferDone(xferDone),
  .busBusyIn(busBusyIn), .reqIn(reqIn), .reqOut(reqOut),
  .grantOut(grantOut), .busBusyOut(busBusyOut), .curLvl(curLvl)
);

// File: tb/busReqChain_bench.sv
`timescale 1ns/1ps
module busReqChain_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] levelSel = '0;
  logic       fairMode = 1'b0;
  logic       xferReq = 1'b0;
  logic       xferDone = 1'b0;
  logic [3:0] grantIn = '0;
  logic [3:0] reqIn = '0;
  logic       busBusyIn = 1'b0;
  logic [3:0] reqOut, grantOut;
  logic       busBusyOut, owned;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  busReqChain u_busReqChain (
    .clk(clk), .rstN(rstN), .levelSel(levelSel), .fairMode(fairMode),
    .xferReq(xferReq), .xferDone(xferDone), .grantIn(grantIn),
    .reqIn(reqIn), .busBusyIn(busBusyIn), .reqOut(reqOut),
    .grantOut(grantOut), .busBusyOut(busBusyOut), .owned(owned)
  );

  // {level, grant pattern}: idle block, grantOut must equal the pattern
  localparam logic [5:0] VEC [8] = '{
    6'b00_0001, 6'b00_1110, 6'b01_0010, 6'b01_1101,
    6'b10_0100, 6'b10_1011, 6'b11_1000, 6'b11_0111
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 reqOut", 32'(reqOut), 0);
    check("R1 grantOut", 32'(grantOut), 0);
    check("R1 busy/owned", {busBusyOut, owned}, 0);
    rstN = 1'b1;
    tick(2);

    // R5 / R6 pass-through table
    for (int i = 0; i < 8; i++) begin
      levelSel = VEC[i][5:4];
      grantIn  = VEC[i][3:0];
      tick(6);
      check("R5 R6 table grantOut", 32'(grantOut), 32'(VEC[i][3:0]));
      check("R5 table reqOut", 32'(reqOut), 0);
      grantIn = '0;
      tick(4);
    end

    // R2 request on level 2
    levelSel = 2'd2; xferReq = 1'b1;
    tick(1);
    check("R2 reqOut", 32'(reqOut), 32'h4);
    // R3 claim latency
    grantIn = 4'b0100;
    tick(3);
    check("R3 busy not yet", 32'(busBusyOut), 0);
    tick(1);
    check("R3 busy/owned", {busBusyOut, owned}, 32'h3);
    check("R3 own grant held", 32'(grantOut[2]), 0);
    // R5 other level forwarded while owning
    grantIn = 4'b0101;
    tick(2);
    check("R5 while owning", 32'(grantOut), 32'h1);
    // R2 level change ignored while owning
    levelSel = 2'd0;
    tick(1);
    check("R2 level latched", 32'(reqOut), 32'h4);
    // R9 release
    levelSel = 2'd2;
    xferDone = 1'b1; xferReq = 1'b0;
    tick(1);
    xferDone = 1'b0;
    check("R9 release", {reqOut, busBusyOut, owned}, 0);
    // R10 hold-off
    tick(5);
    check("R10 holdoff grantOut", 32'(grantOut), 32'h1);
    grantIn = '0;
    tick(4);
    check("R10 after drop", 32'(grantOut), 0);

    // R8 glitch filter
    levelSel = 2'd1; xferReq = 1'b1;
    tick(1);
    check("R2 level 1", 32'(reqOut), 32'h2);
    grantIn = 4'b0010;
    tick(1);
    grantIn = '0;
    tick(6);
    check("R8 no claim", 32'(busBusyOut), 0);
    check("R8 no forward", 32'(grantOut), 0);

    // R4 bus busy elsewhere
    busBusyIn = 1'b1; grantIn = 4'b0010;
    tick(6);
    check("R4 waits", 32'(busBusyOut), 0);
    check("R4 still requesting", 32'(reqOut), 32'h2);
    busBusyIn = 1'b0;
    tick(1);
    check("R4 claim after idle", 32'(busBusyOut), 1);
    xferDone = 1'b1; xferReq = 1'b0;
    tick(1);
    xferDone = 1'b0; grantIn = '0;
    tick(4);

    // R11 withdraw
    levelSel = 2'd0; xferReq = 1'b1;
    tick(1);
    check("R11 requested", 32'(reqOut), 32'h1);
    xferReq = 1'b0;
    tick(1);
    check("R11 withdrawn", 32'(reqOut), 0);

    // R6 forwarding own level, request deferred
    levelSel = 2'd3; grantIn = 4'b1000;
    tick(3);
    check("R6 not yet", 32'(grantOut), 0);
    tick(1);
    check("R6 forwarded", 32'(grantOut), 32'h8);
    xferReq = 1'b1;
    tick(3);
    check("R6 no request while fwd", 32'(reqOut), 0);
    check("R6 still fwd", 32'(grantOut), 32'h8);
    grantIn = '0;
    tick(2);
    check("R6 fwd lingers", 32'(grantOut), 32'h8);
    tick(1);
    check("R6 fwd ends", 32'(grantOut), 0);
    tick(1);
    check("R6 request after fwd", 32'(reqOut), 32'h8);
    xferReq = 1'b0;
    tick(1);

    // R7 fair mode
    fairMode = 1'b1; reqIn = 4'b1000; xferReq = 1'b1;
    tick(5);
    check("R7 deferred", 32'(reqOut), 0);
    reqIn = '0;
    tick(1);
    check("R7 released", 32'(reqOut), 32'h8);
    xferReq = 1'b0;
    tick(1);
    fairMode = 1'b0; reqIn = 4'b1000; xferReq = 1'b1;
    tick(1);
    check("R7 non-fair ignores reqIn", 32'(reqOut), 32'h8);
    xferReq = 1'b0; reqIn = '0;
    tick(2);
    check("R12 idle reqOut", 32'(reqOut), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule